// File: doc/BRIEF.md
# I2C Master Bit Timing Engine

This block turns single-bit bus commands into SCL and SDA waveforms for an I2C master. Its timing comes from one bus clock. The commands are start, repeated start, write bit, read bit and stop. Each line is open-drain: the engine only asserts a pull-low enable, and it reads the real line level back through a synchronizer. Byte shifting, acknowledge handling, arbitration and slave clock stretching belong to the layer above, which issues one command at a time and waits for the done pulse.

Every phase is a base count of bus clocks multiplied by a divider value N. The divider is captured when a command is accepted. A divider of zero behaves as one. The SCL low period is split into two equal halves, and the data change sits on the boundary between them, so the change moves with N and always falls in the middle of the low time. The high-period count does not start when SCL is released. It starts only once SCL is sensed high, so a slow rising edge adds to the high time and never takes from it.

Top module: `i2c_bit_engine`

## Requirements
- R1: While reset is held and right after it is released, both pull-low enables are 0 (lines released) and done is 0.
- R2: Command code 1 (start) pulls SDA low in the first cycle after acceptance, while SCL stays released. SCL is pulled low exactly 6N clocks later.
- R3: For codes 2 to 5, any SDA change in the low period comes exactly 7N clocks after acceptance, which is at least 7N after the preceding SCL fall. SCL is released exactly 14N clocks after acceptance, so the setup time before the rise is 7N.
- R4: After SCL is released, the high-period count starts only once SCL is sensed high. For write and read, SCL is pulled low again between 10N and 10N+4 clocks after the line is seen high.
- R5: Code 3 (write) drives SDA low for wr_bit_i=0 and releases it for wr_bit_i=1, and holds that value through the high period.
- R6: Code 4 (read) releases SDA. It samples the line at the middle of the SCL high period and presents the value on rd_bit_o in the done cycle.
- R7: Code 5 (stop) pulls SDA low in the low period. It releases SDA between 10N and 10N+4 clocks after SCL is seen high, which leaves both lines released.
- R8: Code 2 (repeated start) releases SDA in the low period. It pulls SDA low between 20N and 20N+4 clocks after SCL is seen high, then pulls SCL low exactly 6N clocks after that.
- R9: N is div_i captured at acceptance, and a value of 0 acts as 1. Changing div_i during a command has no effect on that command.
- R10: done_o is a single-cycle pulse that coincides with the final line change. A command offered while another is running, and code 0 or codes 6 and 7, are ignored: no line change and no done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_i | input | DIV_W | Phase-length multiplier N |
| cmd_valid_i | input | 1 | Command offered this cycle |
| cmd_i | input | 3 | 0 none, 1 start, 2 repeated start, 3 write, 4 read, 5 stop |
| wr_bit_i | input | 1 | Data bit for a write command |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| done_o | output | 1 | Command complete pulse |
| rd_bit_o | output | 1 | Bit sampled by the last read |

## Verification
The bench models each line with a pull-up that rises after a random delay. It checks that the high time is measured from the sensed rise: a design that counts from the release would give short high periods whenever the delay is non-zero. It uses divider zero, where a design without the clamp would produce zero-length or wrapped phases. It also changes the divider and fires extra commands while a bit is in progress; a design that re-reads the divider or accepts a command while busy would produce the wrong phase lengths or a stray done. Repeated starts and stops are issued with SDA both held and released beforehand, which catches a design that assumes one starting level for the low-period edge. Read values are driven from the slave side and compared at done.

// File: rtl/i2c_eng_pkg.sv
package i2c_eng_pkg;

  typedef enum logic [2:0] {
    CMD_NOP    = 3'd0,
    CMD_START  = 3'd1,
    CMD_RSTART = 3'd2,
    CMD_WRITE  = 3'd3,
    CMD_READ   = 3'd4,
    CMD_STOP   = 3'd5
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HOLD_ACT,
    ST_LOW_A,
    ST_LOW_B,
    ST_RISE,
    ST_HIGH
  } state_e;

endpackage

// File: rtl/line_sync.sv
module line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES:0] chain;
  assign chain[0] = d_i;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain[g+1] <= 1'b1;
      else         chain[g+1] <= chain[g];
    end
  end

  assign q_o = chain[STAGES];

endmodule

// File: rtl/phase_timer.sv
module phase_timer #(
  parameter int unsigned CW = 13
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] len_i,
  output logic [CW-1:0] cnt_o,
  output logic          exp_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= len_i - CW'(1);
    else if (cnt_q != '0)    cnt_q <= cnt_q - CW'(1);
  end

  assign cnt_o = cnt_q;
  assign exp_o = (cnt_q == '0);

  // R9
  load_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(len_i) - CW'(1));

  // R3
  count_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - CW'(1));

endmodule

// File: rtl/i2c_bit_fsm.sv
module i2c_bit_fsm
  import i2c_eng_pkg::*;
#(
  parameter int unsigned DIV_W      = 8,
  parameter int unsigned CW         = 13,
  parameter int unsigned START_HOLD = 6,
  parameter int unsigned LOW_HOLD   = 7,
  parameter int unsigned HIGH_MIN   = 10,
  parameter int unsigned STOP_SETUP = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             cmd_valid_i,
  input  logic [2:0]       cmd_i,
  input  logic             wr_bit_i,
  input  logic             scl_hi_i,
  input  logic             sda_hi_i,
  input  logic             tmr_exp_i,
  input  logic [CW-1:0]    tmr_cnt_i,
  output logic             tmr_load_o,
  output logic [CW-1:0]    tmr_len_o,
  output logic             scl_oe_o,
  output logic             sda_oe_o,
  output logic             done_o,
  output logic             rd_bit_o
);

  localparam int unsigned RS_SETUP = 2 * STOP_SETUP;

  state_e        state_q, state_d;
  cmd_e          cmd_q, cmd_d;
  logic          bit_q, bit_d;
  logic [CW-1:0] n_q, n_d, n_in, high_len;
  logic          scl_oe_q, scl_oe_d, sda_oe_q, sda_oe_d;
  logic          done_q, done_d, rd_q, rd_d;
  logic          load;
  logic [CW-1:0] len;

  function automatic logic [CW-1:0] scale(input int unsigned base, input logic [CW-1:0] n);
    return CW'(base) * n;
  endfunction

  // divider 0 behaves as 1
  assign n_in     = (div_i == '0) ? CW'(1) : CW'(div_i);
  assign high_len = scale(HIGH_MIN, n_q);

  always_comb begin
    state_d  = state_q;
    cmd_d    = cmd_q;
    bit_d    = bit_q;
    n_d      = n_q;
    scl_oe_d = scl_oe_q;
    sda_oe_d = sda_oe_q;
    done_d   = 1'b0;
    rd_d     = rd_q;
    load     = 1'b0;
    len      = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_valid_i) begin
          case (cmd_i)
            3'd1: begin
              cmd_d    = CMD_START;
              n_d      = n_in;
              sda_oe_d = 1'b1;
              load     = 1'b1;
              len      = scale(START_HOLD, n_in);
              state_d  = ST_HOLD_ACT;
            end
            3'd2, 3'd3, 3'd4, 3'd5: begin
              cmd_d   = cmd_e'(cmd_i);
              n_d     = n_in;
              bit_d   = wr_bit_i;
              load    = 1'b1;
              len     = scale(LOW_HOLD, n_in);
              state_d = ST_LOW_A;
            end
            default: ;
          endcase
        end
      end
      ST_HOLD_ACT: begin
        if (tmr_exp_i) begin
          scl_oe_d = 1'b1;
          done_d   = 1'b1;
          state_d  = ST_IDLE;
        end
      end
      ST_LOW_A: begin
        if (tmr_exp_i) begin
          case (cmd_q)
            CMD_WRITE:           sda_oe_d = ~bit_q;
            CMD_READ, CMD_RSTART: sda_oe_d = 1'b0;
            CMD_STOP:            sda_oe_d = 1'b1;
            default: ;
          endcase
          // equal halves centre the data edge in the low period
          load    = 1'b1;
          len     = scale(LOW_HOLD, n_q);
          state_d = ST_LOW_B;
        end
      end
      ST_LOW_B: begin
        if (tmr_exp_i) begin
          scl_oe_d = 1'b0;
          state_d  = ST_RISE;
        end
      end
      ST_RISE: begin
        if (scl_hi_i) begin
          load    = 1'b1;
          state_d = ST_HIGH;
          case (cmd_q)
            CMD_RSTART: len = scale(RS_SETUP, n_q);
            CMD_STOP:   len = scale(STOP_SETUP, n_q);
            default:    len = high_len;
          endcase
        end
      end
      ST_HIGH: begin
        if (cmd_q == CMD_READ && tmr_cnt_i == (high_len >> 1)) rd_d = sda_hi_i;
        if (tmr_exp_i) begin
          case (cmd_q)
            CMD_RSTART: begin
              sda_oe_d = 1'b1;
              load     = 1'b1;
              len      = scale(START_HOLD, n_q);
              state_d  = ST_HOLD_ACT;
            end
            CMD_STOP: begin
              sda_oe_d = 1'b0;
              done_d   = 1'b1;
              state_d  = ST_IDLE;
            end
            default: begin
              scl_oe_d = 1'b1;
              done_d   = 1'b1;
              state_d  = ST_IDLE;
            end
          endcase
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cmd_q    <= CMD_NOP;
      bit_q    <= 1'b0;
      n_q      <= CW'(1);
      scl_oe_q <= 1'b0;
      sda_oe_q <= 1'b0;
      done_q   <= 1'b0;
      rd_q     <= 1'b0;
    end else begin
      state_q  <= state_d;
      cmd_q    <= cmd_d;
      bit_q    <= bit_d;
      n_q      <= n_d;
      scl_oe_q <= scl_oe_d;
      sda_oe_q <= sda_oe_d;
      done_q   <= done_d;
      rd_q     <= rd_d;
    end
  end

  assign tmr_load_o = load;
  assign tmr_len_o  = len;
  assign scl_oe_o   = scl_oe_q;
  assign sda_oe_o   = sda_oe_q;
  assign done_o     = done_q;
  assign rd_bit_o   = rd_q;

  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  // R10
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |=> (cmd_q == $past(cmd_q)));

  // R2
  scl_fall_timed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(scl_oe_q) |-> $past(tmr_exp_i));

  // R3
  sda_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_q) |-> ($past(tmr_exp_i) || $past(state_q == ST_IDLE && cmd_valid_i)));

  // R4
  high_needs_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HIGH && $past(state_q) == ST_RISE) |-> $past(scl_hi_i));

  // R6
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_HIGH) |=> $stable(rd_q));

  // R7
  stop_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && cmd_q == CMD_STOP) |-> (!scl_oe_q && !sda_oe_q));

endmodule

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine #(
  parameter int unsigned DIV_W       = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned START_HOLD  = 6,
  parameter int unsigned LOW_HOLD    = 7,
  parameter int unsigned HIGH_MIN    = 10,
  parameter int unsigned STOP_SETUP  = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             cmd_valid_i,
  input  logic [2:0]       cmd_i,
  input  logic             wr_bit_i,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             scl_oe_o,
  output logic             sda_oe_o,
  output logic             done_o,
  output logic             rd_bit_o
);

  localparam int unsigned BASE_SUM = 2 * STOP_SETUP + HIGH_MIN + START_HOLD + LOW_HOLD;
  localparam int unsigned CW       = DIV_W + $clog2(BASE_SUM + 1);

  logic          scl_hi, sda_hi;
  logic          tmr_load, tmr_exp;
  logic [CW-1:0] tmr_len, tmr_cnt;

  line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(scl_i), .q_o(scl_hi)
  );

  line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(sda_i), .q_o(sda_hi)
  );

  phase_timer #(.CW(CW)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(tmr_load),
    .len_i (tmr_len),
    .cnt_o (tmr_cnt),
    .exp_o (tmr_exp)
  );

  i2c_bit_fsm #(
    .DIV_W     (DIV_W),
    .CW        (CW),
    .START_HOLD(START_HOLD),
    .LOW_HOLD  (LOW_HOLD),
    .HIGH_MIN  (HIGH_MIN),
    .STOP_SETUP(STOP_SETUP)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .div_i      (div_i),
    .cmd_valid_i(cmd_valid_i),
    .cmd_i      (cmd_i),
    .wr_bit_i   (wr_bit_i),
    .scl_hi_i   (scl_hi),
    .sda_hi_i   (sda_hi),
    .tmr_exp_i  (tmr_exp),
    .tmr_cnt_i  (tmr_cnt),
    .tmr_load_o (tmr_load),
    .tmr_len_o  (tmr_len),
    .scl_oe_o   (scl_oe_o),
    .sda_oe_o   (sda_oe_o),
    .done_o     (done_o),
    .rd_bit_o   (rd_bit_o)
  );

endmodule

// File: tb/tb_i2c_bit_engine.sv
`timescale 1ns/1ps
module tb_i2c_bit_engine;

  localparam int DIV_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [DIV_W-1:0] div = 8'd1;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd = 3'd0;
  logic wr_bit = 1'b0;
  logic scl_line = 1'b1;
  logic sda_line = 1'b1;
  logic slave_low = 1'b0;
  logic scl_oe, sda_oe, done, rd_bit;
  int   rise_dly = 0;
  int   rel_cnt = 0;
  int   checks = 0, errors = 0, cyc = 0, last_fall = 0;

  always #2 clk = ~clk;

  // pull-up model: SCL rises rise_dly cycles after release
  always @(negedge clk) begin
    rel_cnt  <= scl_oe ? 0 : ((rel_cnt < 1000) ? rel_cnt + 1 : rel_cnt);
    scl_line <= !scl_oe && (rel_cnt >= rise_dly);
    sda_line <= !(sda_oe || slave_low);
  end

  i2c_bit_engine dut (
    .clk_i(clk), .rst_ni(rst_n), .div_i(div), .cmd_valid_i(cmd_valid),
    .cmd_i(cmd), .wr_bit_i(wr_bit), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .done_o(done), .rd_bit_o(rd_bit)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
  endtask

  function automatic bit in_win(input int v, input int lo);
    return (v >= lo) && (v <= lo + 4);
  endfunction

  task automatic run_cmd(input int c, input bit b, input bit slv, input int dv, input int n, input bit poke);
    int t0, t_lo, t_hi, t_rel, t_line, t_fall, t_done;
    bit p_scl, p_sda, p_line, sda0, rdv;
    t_lo = -1; t_hi = -1; t_rel = -1; t_line = -1; t_fall = -1; t_done = -1; rdv = 1'b0;
    slave_low = (c == 4) ? slv : 1'b0;
    div = dv[DIV_W-1:0]; cmd_valid = 1'b1; cmd = c[2:0]; wr_bit = b;
    sda0 = sda_oe; p_scl = scl_oe; p_sda = sda_oe; p_line = scl_line;
    step();
    cmd_valid = 1'b0;
    t0 = cyc;
    for (int k = 0; k < 5000; k++) begin
      if (scl_oe != p_scl) begin if (scl_oe) t_fall = cyc; else t_rel = cyc; end
      if (sda_oe != p_sda) begin if (scl_oe) t_lo = cyc; else t_hi = cyc; end
      if (scl_line && !p_line) t_line = cyc;
      p_scl = scl_oe; p_sda = sda_oe; p_line = scl_line;
      if (done) begin t_done = cyc; rdv = rd_bit; break; end
      if (poke && k == 3) begin
        cmd_valid = 1'b1; cmd = 3'($urandom_range(1, 5)); div = 8'($urandom_range(0, 255));
      end else if (poke && k == 4) begin
        cmd_valid = 1'b0; div = dv[DIV_W-1:0];
      end
      step();
    end
    slave_low = 1'b0;
    chk(t_done >= 0, "R10 done seen", t_done, 1);
    case (c)
      1: begin
        chk(t_hi == t0, "R2 sda low at accept", t_hi - t0, 0);
        chk(t_fall - t_hi == 6 * n, "R2 start hold", t_fall - t_hi, 6 * n);
        chk(t_done == t_fall, "R10 done with scl fall", t_done, t_fall);
      end
      2: begin
        if (sda0) chk(t_lo - t0 == 7 * n, "R8 sda release in low", t_lo - t0, 7 * n);
        chk(t_rel - t0 == 14 * n, "R3 scl release", t_rel - t0, 14 * n);
        chk(in_win(t_hi - t_line, 20 * n), "R8 repeated start setup", t_hi - t_line, 20 * n);
        chk(t_fall - t_hi == 6 * n, "R8 repeated start hold", t_fall - t_hi, 6 * n);
        chk(t_done == t_fall, "R10 done with scl fall", t_done, t_fall);
      end
      3, 4: begin
        if (c == 3) chk(sda_oe == !b, "R5 write level", sda_oe, !b);
        else begin
          chk(sda_oe == 1'b0, "R6 sda released", sda_oe, 0);
          chk(rdv == !slv, "R6 read value", rdv, !slv);
        end
        if (t_lo >= 0) begin
          chk(t_lo - t0 == 7 * n, "R3 data change point", t_lo - t0, 7 * n);
          chk(t_lo - last_fall >= 7 * n, "R3 data hold", t_lo - last_fall, 7 * n);
        end
        chk(t_rel - t0 == 14 * n, "R3 scl release", t_rel - t0, 14 * n);
        chk(in_win(t_fall - t_line, 10 * n), "R4 high period", t_fall - t_line, 10 * n);
        chk(t_done == t_fall, "R10 done with scl fall", t_done, t_fall);
      end
      default: begin
        if (!sda0) chk(t_lo - t0 == 7 * n, "R7 sda low in low period", t_lo - t0, 7 * n);
        chk(t_rel - t0 == 14 * n, "R3 scl release", t_rel - t0, 14 * n);
        chk(in_win(t_hi - t_line, 10 * n), "R7 stop setup", t_hi - t_line, 10 * n);
        chk(!scl_oe && !sda_oe, "R7 bus released", {scl_oe, sda_oe}, 0);
        chk(t_done == t_hi, "R10 done with sda release", t_done, t_hi);
      end
    endcase
    if (t_fall >= 0) last_fall = t_fall;
  endtask

  task automatic idle_check(input int cycles, input string req);
    bit s0, d0, bad;
    s0 = scl_oe; d0 = sda_oe; bad = 1'b0;
    for (int k = 0; k < cycles; k++) begin
      step();
      if (scl_oe != s0 || sda_oe != d0 || done) bad = 1'b1;
    end
    chk(!bad, req, bad, 0);
  endtask

  task automatic frame(input int n, input int dv, input bit poke);
    int nb;
    run_cmd(1, 1'b0, 1'b0, dv, n, 1'b0);
    nb = 1 + int'($urandom % 3);
    for (int i = 0; i < nb; i++) begin
      if ($urandom % 2) run_cmd(3, 1'($urandom), 1'b0, dv, n, poke && i == 0);
      else              run_cmd(4, 1'b0, 1'($urandom), dv, n, poke && i == 0);
    end
    if ($urandom % 2) begin
      run_cmd(2, 1'b0, 1'b0, dv, n, 1'b0);
      run_cmd(3, 1'($urandom), 1'b0, dv, n, 1'b0);
    end
    run_cmd(5, 1'b0, 1'b0, dv, n, 1'b0);
    for (int g = 0; g < int'($urandom % 6); g++) step();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (4) step();
    // R1 reset state
    chk(!scl_oe && !sda_oe && !done, "R1 in reset", {scl_oe, sda_oe, done}, 0);
    rst_n = 1'b1;
    repeat (3) step();
    chk(!scl_oe && !sda_oe && !done, "R1 after reset", {scl_oe, sda_oe, done}, 0);

    // R10 undefined and empty codes ignored
    cmd_valid = 1'b1; cmd = 3'd0; step();
    cmd = 3'd6; step();
    cmd = 3'd7; step();
    cmd_valid = 1'b0;
    idle_check(40, "R10 idle codes ignored");

    // R9 divider 0 acts as 1, mixed sda start levels
    run_cmd(1, 1'b0, 1'b0, 0, 1, 1'b0);
    run_cmd(3, 1'b0, 1'b0, 0, 1, 1'b0);
    run_cmd(3, 1'b1, 1'b0, 0, 1, 1'b0);
    run_cmd(4, 1'b0, 1'b1, 0, 1, 1'b0);
    run_cmd(2, 1'b0, 1'b0, 0, 1, 1'b0);
    run_cmd(3, 1'b0, 1'b0, 0, 1, 1'b0);
    run_cmd(2, 1'b0, 1'b0, 0, 1, 1'b0);
    run_cmd(4, 1'b0, 1'b0, 0, 1, 1'b0);
    run_cmd(5, 1'b0, 1'b0, 0, 1, 1'b0);
    idle_check(10, "R7 bus stays idle");

    // R4 slow rise
    rise_dly = 3;
    frame(1, 1, 1'b0);
    frame(3, 3, 1'b0);

    // R9 R10 divider change and commands while busy
    rise_dly = 1;
    run_cmd(1, 1'b0, 1'b0, 2, 2, 1'b0);
    run_cmd(3, 1'b1, 1'b0, 2, 2, 1'b1);
    idle_check(20, "R10 busy command ignored");
    run_cmd(4, 1'b0, 1'b0, 2, 2, 1'b1);
    run_cmd(5, 1'b0, 1'b0, 2, 2, 1'b0);

    for (int f = 0; f < 30; f++) begin
      int n;
      n = 1 + int'($urandom % 4);
      rise_dly = int'($urandom % 4);
      frame(n, n, f % 7 == 3);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule